// File: doc/BRIEF.md
# Retired-Address Breakpoint Trigger

This block is a single hardware breakpoint for a processor core. Software or an external debugger programs a match address and a small control word through a CSR-style port. The core then reports every instruction it retires, with its address. When the trigger is armed and a retired address equals the programmed value exactly, the block raises one of two request lines in the next cycle. One line asks the core to enter debug mode. The other asks it to take an ordinary machine-mode breakpoint exception. Because the request follows retirement, the matching instruction has already executed when the core reacts.

Almost every field of the control word is fixed. Only three fields can be written: an arm bit, an action field, and a debugger-ownership bit. Once the debugger claims ownership, accesses made outside debug mode can no longer change the trigger. Ownership itself can only be changed while the core is in debug mode. The trigger stays silent while the core is in debug mode, so the debugger's own code never trips it.

Top module: `addr_trig_unit`

## Requirements
- R1: After reset, address 0x7a1 reads 0x20040040 (0x20040048 when user-mode support is enabled), 0x7a2 reads 0, 0x7a4 reads 4, 0x7a0 reads 0, and both request outputs are low.
- R2: Addresses 0x7a0, 0x7a3, 0x7a5, 0x7a8 and 0x7aa read zero and ignore writes. A write to 0x7a4 leaves it reading 4.
- R3: In the control word at 0x7a1, only bit 2 (arm), bits 15:12 (action) and bit 27 (owner) take written values. Action value 0001 selects debug entry, and any other written value stores 0000, which selects the exception. All other bits keep their fixed values.
- R4: Bit 27 of 0x7a1 changes only on a write made while the debug-mode flag is high. A write made outside debug mode leaves it unchanged.
- R5: While bit 27 is set, writes to 0x7a1 and 0x7a2 made outside debug mode have no effect.
- R6: 0x7a2 is a full-width read/write match address.
- R7: When armed, a valid retired address equal to the match address raises, one cycle later, exactly one output. With action 0001 it raises `fire_debug`; with action 0000 it raises `fire_break`.
- R8: There is no request when the trigger is disarmed, when the retire-valid input is low, or when the address differs in any single bit.
- R9: There is no request for an instruction that retires while the debug-mode flag is high.
- R10: A match fires in machine mode (privilege 11). In user mode (privilege 00) it fires only when user-mode support is enabled, and that same option sets bit 3 of 0x7a1.
- R11: Each matching retirement gives a one-cycle pulse. Matching retirements on consecutive cycles give one pulse each, with no merging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | CSR write strobe |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational from the address) |
| priv_lvl | input | 2 | current privilege, 11 machine, 00 user |
| in_debug | input | 1 | core is in debug mode |
| ret_valid | input | 1 | an instruction retires this cycle |
| ret_pc | input | ADDR_W | address of the retiring instruction |
| fire_debug | output | 1 | request debug-mode entry |
| fire_break | output | 1 | request breakpoint exception |

## Verification
The match path is tested with an exact hit, and with near misses that flip the lowest bit and the highest bit. These show that all address bits are compared. A hit with retire-valid low, one during debug mode, and one in user mode each isolate a single qualifying condition. Back-to-back hits separate a per-retirement pulse from a level. Switching the action field between hits shows which output is chosen. Writing all ones to the control word, with and without debug mode, and then again with ownership held, separates the writable fields, the debug-only ownership bit and the lockout.

// File: rtl/trig_pkg.sv
package trig_pkg;
   localparam logic [11:0] A_SEL   = 12'h7A0;
   localparam logic [11:0] A_CTRL  = 12'h7A1;
   localparam logic [11:0] A_ADDR  = 12'h7A2;
   localparam logic [11:0] A_INFO  = 12'h7A4;

   localparam int TYPE_LSB   = 28;
   localparam int OWNER_BIT  = 27;
   localparam int TIMING_BIT = 18;
   localparam int ACT_LSB    = 12;
   localparam int MEN_BIT    = 6;
   localparam int UEN_BIT    = 3;
   localparam int ARM_BIT    = 2;

   localparam logic [3:0]  TYPE_VAL  = 4'h2;
   localparam logic [3:0]  ACT_DBG_CODE = 4'b0001;
   localparam logic [31:0] INFO_VAL  = 32'h0000_0004;

   localparam logic [1:0] PRIV_M = 2'b11;
   localparam logic [1:0] PRIV_U = 2'b00;

   typedef enum logic {ACT_BREAK = 1'b0, ACT_DEBUG = 1'b1} act_e;

   typedef struct packed {
      logic owner;
      act_e act;
      logic arm;
   } ctrl_t;
endpackage

// File: rtl/trig_csr_regs.sv
module trig_csr_regs
   import trig_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [11:0]       csr_addr,
   input  logic              csr_we,
   input  logic [XLEN-1:0]   csr_wdata,
   input  logic              in_debug,
   output ctrl_t             ctrl_o,
   output logic [ADDR_W-1:0] match_o
);
   ctrl_t             ctrl_q, ctrl_d;
   logic [ADDR_W-1:0] match_q, match_d;
   logic              wr_allow;

   // owner bit locks out accesses made outside debug mode
   assign wr_allow = csr_we && (!ctrl_q.owner || in_debug);

   always_comb begin
      ctrl_d  = ctrl_q;
      match_d = match_q;
      if (wr_allow && csr_addr == A_CTRL) begin
         ctrl_d.arm = csr_wdata[ARM_BIT];
         ctrl_d.act = (csr_wdata[ACT_LSB +: 4] == ACT_DBG_CODE) ? ACT_DEBUG : ACT_BREAK;
         if (in_debug) begin
            ctrl_d.owner = csr_wdata[OWNER_BIT];
         end
      end
      if (wr_allow && csr_addr == A_ADDR) begin
         match_d = csr_wdata[ADDR_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '{owner: 1'b0, act: ACT_BREAK, arm: 1'b0};
         match_q <= '0;
      end else begin
         ctrl_q  <= ctrl_d;
         match_q <= match_d;
      end
   end

   assign ctrl_o  = ctrl_q;
   assign match_o = match_q;

   // R4: ownership cannot move outside debug mode
   assert_owner_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_debug |=> $stable(ctrl_q.owner));

   // R5: locked trigger ignores non-debug writes
   assert_locked_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && ctrl_q.owner && !in_debug) |=> ($stable(match_q) && $stable(ctrl_q)));

   // R6: match address changes only through a write to its address
   assert_match_write_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(csr_we && csr_addr == A_ADDR) |=> $stable(match_q));
endmodule

// File: rtl/trig_csr_rmux.sv
module trig_csr_rmux
   import trig_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int ADDR_W  = 32,
   parameter bit USER_EN = 1'b0
) (
   input  logic [11:0]       csr_addr,
   input  ctrl_t             ctrl,
   input  logic [ADDR_W-1:0] match,
   output logic [XLEN-1:0]   rdata
);
   localparam int PAD_W = XLEN - ADDR_W;

   logic [XLEN-1:0] ctrl_word;
   logic [XLEN-1:0] match_word;

   always_comb begin
      ctrl_word                      = '0;
      ctrl_word[TYPE_LSB +: 4]       = TYPE_VAL;
      ctrl_word[OWNER_BIT]           = ctrl.owner;
      ctrl_word[TIMING_BIT]          = 1'b1;
      ctrl_word[ACT_LSB +: 4]        = {3'b000, ctrl.act};
      ctrl_word[MEN_BIT]             = 1'b1;
      ctrl_word[UEN_BIT]             = USER_EN;
      ctrl_word[ARM_BIT]             = ctrl.arm;
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign match_word = {{PAD_W{1'b0}}, match};
      end else begin : g_full
         assign match_word = match;
      end
   endgenerate

   always_comb begin
      case (csr_addr)
         A_CTRL:  rdata = ctrl_word;
         A_ADDR:  rdata = match_word;
         A_INFO:  rdata = INFO_VAL[XLEN-1:0];
         default: rdata = '0;
      endcase
   end

   // R2: the select slot and spare slots never return data
   always_comb begin
      if (csr_addr == A_SEL) begin
         assert_sel_zero_R2: assert (rdata == '0);
      end
   end
endmodule

// File: rtl/trig_match.sv
module trig_match
   import trig_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter bit USER_EN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  act_e              act,
   input  logic [ADDR_W-1:0] match,
   input  logic              ret_valid,
   input  logic [ADDR_W-1:0] ret_pc,
   input  logic [1:0]        priv_lvl,
   input  logic              in_debug,
   output logic              fire_debug,
   output logic              fire_break
);
   logic priv_ok;
   logic hit;

   generate
      if (USER_EN) begin : g_user
         assign priv_ok = (priv_lvl == PRIV_M) || (priv_lvl == PRIV_U);
      end else begin : g_mach
         assign priv_ok = (priv_lvl == PRIV_M);
      end
   endgenerate

   assign hit = ret_valid && !in_debug && arm && priv_ok && (ret_pc == match);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fire_debug <= 1'b0;
         fire_break <= 1'b0;
      end else begin
         fire_debug <= hit && (act == ACT_DEBUG);
         fire_break <= hit && (act == ACT_BREAK);
      end
   end

   // R7: the chosen output follows the action field of the previous cycle
   assert_debug_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fire_debug |-> ($past(act) == ACT_DEBUG));
   assert_break_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fire_break |-> ($past(act) == ACT_BREAK));

   // R8: requests need an armed trigger and an exact valid match
   assert_exact_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_debug || fire_break) |-> $past(arm && ret_valid && (ret_pc == match)));

   // R9: nothing fires for retirements inside debug mode
   assert_quiet_debug_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_debug || fire_break) |-> $past(!in_debug));
endmodule

// File: rtl/addr_trig_unit.sv
module addr_trig_unit
   import trig_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int ADDR_W  = 32,
   parameter bit USER_EN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [11:0]       csr_addr,
   input  logic              csr_we,
   input  logic [XLEN-1:0]   csr_wdata,
   output logic [XLEN-1:0]   csr_rdata,
   input  logic [1:0]        priv_lvl,
   input  logic              in_debug,
   input  logic              ret_valid,
   input  logic [ADDR_W-1:0] ret_pc,
   output logic              fire_debug,
   output logic              fire_break
);
   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("addr_trig_unit: control word layout needs XLEN of 32");
      end
      if (ADDR_W < 1 || ADDR_W > XLEN) begin : g_bad_addr
         $error("addr_trig_unit: ADDR_W must lie in 1..XLEN");
      end
   endgenerate

   ctrl_t             ctrl;
   logic [ADDR_W-1:0] match;

   trig_csr_regs #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .csr_addr  (csr_addr),
      .csr_we    (csr_we),
      .csr_wdata (csr_wdata),
      .in_debug  (in_debug),
      .ctrl_o    (ctrl),
      .match_o   (match)
   );

   trig_csr_rmux #(.XLEN(XLEN), .ADDR_W(ADDR_W), .USER_EN(USER_EN)) u_rmux (
      .csr_addr (csr_addr),
      .ctrl     (ctrl),
      .match    (match),
      .rdata    (csr_rdata)
   );

   trig_match #(.ADDR_W(ADDR_W), .USER_EN(USER_EN)) u_match (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (ctrl.arm),
      .act        (ctrl.act),
      .match      (match),
      .ret_valid  (ret_valid),
      .ret_pc     (ret_pc),
      .priv_lvl   (priv_lvl),
      .in_debug   (in_debug),
      .fire_debug (fire_debug),
      .fire_break (fire_break)
   );

   // R11: a request is a single-cycle pulse unless another match retired
   assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((fire_debug || fire_break) && !(ret_valid && ret_pc == match)) |=> !(fire_debug || fire_break));
endmodule

// File: tb/addr_trig_unit_bench.sv
module addr_trig_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] csr_addr = '0;
   logic        csr_we = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic [1:0]  priv_lvl = 2'b11;
   logic        in_debug = 1'b0;
   logic        ret_valid = 1'b0;
   logic [31:0] ret_pc = '0;
   logic        fire_debug, fire_break;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   int         due_q[$];
   logic [1:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;   // 50 MHz

   addr_trig_unit u_addr_trig_unit (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .priv_lvl(priv_lvl),
      .in_debug(in_debug), .ret_valid(ret_valid), .ret_pc(ret_pc),
      .fire_debug(fire_debug), .fire_break(fire_break)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare request outputs against scoreboard entries
   always @(negedge clk) begin
      while (due_q.size() > 0 && due_q[0] <= cyc) begin
         automatic int         d = due_q.pop_front();
         automatic logic [1:0] e = exp_q.pop_front();
         automatic string      t = tag_q.pop_front();
         total++;
         if (d != cyc || {fire_debug, fire_break} !== e) begin
            bad++;
            $display("FAIL %s {dbg,brk} act=%b exp=%b (cycle %0d)", t, {fire_debug, fire_break}, e, cyc);
         end
      end
   end

   task automatic push(input logic [1:0] e, input string t);
      due_q.push_back(cyc + 1);
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", t, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic dbg);
      @(negedge clk);
      csr_we = 1'b1; csr_addr = a; csr_wdata = d; in_debug = dbg;
      ret_valid = 1'b0; priv_lvl = 2'b11;
      push(2'b00, "R8 idle");
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string t);
      @(negedge clk);
      csr_we = 1'b0; csr_addr = a; ret_valid = 1'b0;
      push(2'b00, "R8 idle");
      #1 check(t, csr_rdata, exp);
   endtask

   task automatic retire(input logic [31:0] pc, input logic v, input logic dbg,
                         input logic [1:0] pl, input logic [1:0] e, input string t);
      @(negedge clk);
      csr_we = 1'b0; ret_valid = v; ret_pc = pc; in_debug = dbg; priv_lvl = pl;
      push(e, t);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset fire_debug", {31'b0, fire_debug}, 32'h0);
      check("R1 reset fire_break", {31'b0, fire_break}, 32'h0);
      rst_n = 1'b1;
      rd(12'h7A1, 32'h2004_0040, "R1 ctrl reset");
      rd(12'h7A2, 32'h0,         "R1 match reset");
      rd(12'h7A4, 32'h4,         "R1 info");
      rd(12'h7A0, 32'h0,         "R1 select");
      retire(32'h0, 1'b1, 1'b0, 2'b11, 2'b00, "R8 disarmed at reset");

      wr(12'h7A2, 32'h8000_1234, 1'b0);
      rd(12'h7A2, 32'h8000_1234, "R6 match rw");
      foreach (due_q[i]) begin end
      wr(12'h7A0, 32'hFFFF_FFFF, 1'b0); rd(12'h7A0, 32'h0, "R2 select ignores");
      wr(12'h7A3, 32'hFFFF_FFFF, 1'b0); rd(12'h7A3, 32'h0, "R2 7a3 zero");
      wr(12'h7A5, 32'hFFFF_FFFF, 1'b0); rd(12'h7A5, 32'h0, "R2 7a5 zero");
      wr(12'h7A8, 32'hFFFF_FFFF, 1'b0); rd(12'h7A8, 32'h0, "R2 7a8 zero");
      wr(12'h7AA, 32'hFFFF_FFFF, 1'b0); rd(12'h7AA, 32'h0, "R2 7aa zero");
      wr(12'h7A4, 32'h0,         1'b0); rd(12'h7A4, 32'h4, "R2 info fixed");

      wr(12'h7A1, 32'hFFFF_FFFF, 1'b0);
      rd(12'h7A1, 32'h2004_0044, "R3 R4 all-ones outside debug");

      wr(12'h7A1, 32'h0000_1004, 1'b0);
      rd(12'h7A1, 32'h2004_1044, "R3 action debug armed");
      retire(32'h8000_1234, 1'b1, 1'b0, 2'b11, 2'b10, "R7 debug request");
      retire(32'h8000_1235, 1'b1, 1'b0, 2'b11, 2'b00, "R8 low bit miss");
      retire(32'h0000_1234, 1'b1, 1'b0, 2'b11, 2'b00, "R8 high bit miss");
      retire(32'h8000_1234, 1'b0, 1'b0, 2'b11, 2'b00, "R8 not valid");
      retire(32'h8000_1234, 1'b1, 1'b0, 2'b11, 2'b10, "R11 first of pair");
      retire(32'h8000_1234, 1'b1, 1'b0, 2'b11, 2'b10, "R11 second of pair");
      retire(32'h0,         1'b0, 1'b0, 2'b11, 2'b00, "R11 pulse ends");
      retire(32'h8000_1234, 1'b1, 1'b1, 2'b11, 2'b00, "R9 in debug");
      retire(32'h8000_1234, 1'b1, 1'b0, 2'b00, 2'b00, "R10 user mode");

      wr(12'h7A1, 32'h0000_2004, 1'b0);
      retire(32'h8000_1234, 1'b1, 1'b0, 2'b11, 2'b01, "R7 R3 break request");
      wr(12'h7A1, 32'h0000_0000, 1'b0);
      retire(32'h8000_1234, 1'b1, 1'b0, 2'b11, 2'b00, "R8 disarmed");

      wr(12'h7A1, 32'h0800_1004, 1'b1);
      rd(12'h7A1, 32'h2804_1044, "R4 owner set in debug");
      wr(12'h7A1, 32'h0000_0000, 1'b0);
      wr(12'h7A2, 32'h0000_0000, 1'b0);
      rd(12'h7A1, 32'h2804_1044, "R5 ctrl locked");
      rd(12'h7A2, 32'h8000_1234, "R5 match locked");
      retire(32'h8000_1234, 1'b1, 1'b0, 2'b11, 2'b10, "R5 still armed");
      wr(12'h7A1, 32'h0000_0000, 1'b1);
      rd(12'h7A1, 32'h2004_0040, "R4 owner cleared in debug");

      repeat (3) retire(32'h0, 1'b0, 1'b0, 2'b11, 2'b00, "R8 drain");
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule